// File: doc/BRIEF.md
# Flash Region Access Guard

This block sits on the path from a host request port to a serial flash controller and decides, for every host read or write, whether the access may proceed. The flash address space is split into five regions: descriptor, gigabit-Ethernet NVM, management-engine firmware, platform data and BIOS. Each region has a base and a limit in 4 KiB pages and its own host read and write permission bits. The bounds and permissions arrive as configuration inputs. They are normally loaded with read-only for the descriptor, no access for the management-engine firmware, and read-write for the other three.

A descriptor-override strap is sampled once, on the first clock after reset is released. A low strap turns on the override, and from then on every access that lands in an enabled region is granted whatever the configured permissions say. The strap state can be read in a 16-bit status word. A request that is refused never reaches the flash port. Each refusal also sets a sticky error bit, which software clears by writing a 1 to it.

Top module: `flash_region_guard`

## Requirements
- R1: An address belongs to region i when base_i <= addr[ADDR_W-1:12] <= limit_i. Region indices are 0 descriptor, 1 BIOS, 2 management-engine firmware, 3 gigabit-Ethernet, 4 platform data. When regions overlap, the lowest index decides the permission.
- R2: A region whose limit page is below its base page is disabled. A request whose address lies in no enabled region is denied, whether or not the override is active.
- R3: Without the override, a read (hst_we=0) is granted only when the read permission bit of the owning region is 1, and a write (hst_we=1) only when its write permission bit is 1. Bit i of cfg_rd_perm and cfg_wr_perm belongs to region i.
- R4: The strap is sampled on the first rising clock edge with rst_n high. A low level enables the override. Later strap changes have no effect until the next reset.
- R5: With the override enabled, reads and writes are granted in every enabled region regardless of cfg_rd_perm and cfg_wr_perm.
- R6: A granted request appears at the flash port in the same cycle, with fl_req=1 and fl_we, fl_addr and fl_wdata equal to the host values. A denied request gives fl_req=0 and hst_deny=1 in that cycle.
- R7: A denied request sets sts_rdata bit 0 at the next clock edge. The bit stays set until a cycle with sts_wr=1 and sts_wdata bit 0 = 1, and writing 0 to bit 0 leaves it unchanged. When a new denial and a clear fall in the same cycle, the denial wins.
- R8: sts_rdata bit 13 is 1 while the descriptor is not overridden and 0 once it is. All bits other than 0 and 13 read 0, and the value during and just after reset is 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_n | input | 1 | Descriptor-override strap, low enables override |
| cfg_base | input | NREG*(ADDR_W-12) | Base page per region, region i at [i*(ADDR_W-12) +: ADDR_W-12] |
| cfg_limit | input | NREG*(ADDR_W-12) | Limit page per region, same packing |
| cfg_rd_perm | input | NREG | Host read permission per region |
| cfg_wr_perm | input | NREG | Host write permission per region |
| hst_req | input | 1 | Host request valid |
| hst_we | input | 1 | Host request is a write |
| hst_addr | input | ADDR_W | Host flash byte address |
| hst_wdata | input | DATA_W | Host write data |
| hst_deny | output | 1 | Current request is refused |
| fl_req | output | 1 | Request forwarded to flash controller |
| fl_we | output | 1 | Forwarded write flag |
| fl_addr | output | ADDR_W | Forwarded address |
| fl_wdata | output | DATA_W | Forwarded write data |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 16 | Status write data, bit 0 write-1-to-clear |
| sts_rdata | output | 16 | Status: bit 13 not-overridden, bit 0 access error |

## Verification
Region decoding has no state, so a wrong hit, a wrong priority or a wrong permission selection shows at fl_req and hst_deny in the very cycle the request is presented. The two registers in the block show up differently. A mis-latched override flips sts_rdata bit 13 from the first clock after reset and also opens or closes whole regions. A broken error register shows one edge after a denial, or after a clear, as a wrong sts_rdata bit 0. The bench therefore reads the status one edge after every vector and checks that the override holds while the strap moves.

// File: rtl/flash_region_guard.sv
module flash_region_guard #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int NREG    = 5,
  parameter int PAGE_SH = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          strap_n,
  input  logic [NREG*(ADDR_W-12)-1:0]   cfg_base,
  input  logic [NREG*(ADDR_W-12)-1:0]   cfg_limit,
  input  logic [NREG-1:0]               cfg_rd_perm,
  input  logic [NREG-1:0]               cfg_wr_perm,
  input  logic                          hst_req,
  input  logic                          hst_we,
  input  logic [ADDR_W-1:0]             hst_addr,
  input  logic [DATA_W-1:0]             hst_wdata,
  output logic                          hst_deny,
  output logic                          fl_req,
  output logic                          fl_we,
  output logic [ADDR_W-1:0]             fl_addr,
  output logic [DATA_W-1:0]             fl_wdata,
  input  logic                          sts_wr,
  input  logic [15:0]                   sts_wdata,
  output logic [15:0]                   sts_rdata
);

  localparam int PG_W = ADDR_W - PAGE_SH;

  logic [PG_W-1:0] page;
  logic [NREG-1:0] hit, sel;
  logic            perm_ok, grant;
  logic            sampled_q, ovr_q, err_q;
  logic            unused_wbits;

  assign page = hst_addr[ADDR_W-1:PAGE_SH];

  for (genvar i = 0; i < NREG; i++) begin : g_rgn
    logic [PG_W-1:0] base, lim;
    assign base   = cfg_base[i*PG_W +: PG_W];
    assign lim    = cfg_limit[i*PG_W +: PG_W];
    assign hit[i] = (lim >= base) && (page >= base) && (page <= lim);
  end

  // lowest index wins on overlap
  assign sel     = hit & (~hit + NREG'(1));
  assign perm_ok = hst_we ? |(sel & cfg_wr_perm) : |(sel & cfg_rd_perm);
  assign grant   = (|hit) && (ovr_q || perm_ok);

  assign hst_deny = hst_req & ~grant;
  assign fl_req   = hst_req & grant;
  assign fl_we    = hst_we;
  assign fl_addr  = hst_addr;
  assign fl_wdata = hst_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else if (!sampled_q) begin
      sampled_q <= 1'b1;
      ovr_q     <= ~strap_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      err_q <= 1'b0;
    else if (hst_deny)               err_q <= 1'b1;
    else if (sts_wr && sts_wdata[0]) err_q <= 1'b0;
  end

  assign sts_rdata    = {2'b00, ~ovr_q, 12'h000, err_q};
  assign unused_wbits = ^sts_wdata[15:1];

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  p_unmapped_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_req && !(|hit)) |-> hst_deny);

  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sampled_q |=> $stable(ovr_q));

  p_ovr_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && hst_req && (|hit)) |-> fl_req);

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hst_deny |=> sts_rdata[0]);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rdata[0] && !(sts_wr && sts_wdata[0])) |=> sts_rdata[0]);

  p_presample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sampled_q |-> sts_rdata[13]);

endmodule

// File: tb/test_flash_region_guard.sv
`timescale 1ns/1ps
module test_flash_region_guard;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int NR = 5;
  localparam int PW = AW - 12;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_n = 1'b1;
  logic [NR*PW-1:0] cfg_base, cfg_limit;
  logic [NR-1:0] cfg_rd_perm, cfg_wr_perm;
  logic hst_req = 1'b0, hst_we = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [DW-1:0] hst_wdata = '0;
  logic hst_deny, fl_req, fl_we;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic sts_wr = 1'b0;
  logic [15:0] sts_wdata = '0;
  logic [15:0] sts_rdata;

  int nchk = 0, nfail = 0;
  logic err_exp = 1'b0;

  always #2.5 clk = ~clk;

  flash_region_guard #(.ADDR_W(AW), .DATA_W(DW), .NREG(NR), .PAGE_SH(12)) i_flash_region_guard (
    .clk(clk), .rst_n(rst_n), .strap_n(strap_n),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cfg_rd_perm(cfg_rd_perm), .cfg_wr_perm(cfg_wr_perm),
    .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_deny(hst_deny), .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata));

  // {we, addr, expected grant} with default permissions and no override
  localparam logic [AW+1:0] VEC [NV] = '{
    {1'b0, 24'h000010, 1'b1},  // descriptor read
    {1'b1, 24'h000010, 1'b0},  // descriptor write
    {1'b0, 24'h001000, 1'b1},  // gbe read
    {1'b1, 24'h002FFC, 1'b1},  // gbe write, top page
    {1'b0, 24'h003000, 1'b0},  // me read
    {1'b1, 24'h1FF000, 1'b0},  // me write
    {1'b0, 24'h180000, 1'b0},  // me/pd overlap, me wins
    {1'b0, 24'h200000, 1'b1},  // bios read
    {1'b1, 24'hEFFFFF, 1'b1},  // bios write, top byte
    {1'b0, 24'hF00000, 1'b0},  // unmapped
    {1'b1, 24'hF80000, 1'b0}   // unmapped write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_rgn(input int i, input logic [PW-1:0] b, input logic [PW-1:0] l);
    cfg_base[i*PW +: PW]  = b;
    cfg_limit[i*PW +: PW] = l;
  endtask

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_addr = a; hst_wdata = d;
    #1;
  endtask

  task automatic idle_check_err(input string req, input logic exp);
    @(negedge clk);
    hst_req = 1'b0; sts_wr = 1'b0;
    #1;
    chk(req, {31'd0, sts_rdata[0]}, {31'd0, exp});
  endtask

  initial begin
    cfg_base = '0; cfg_limit = '0;
    set_rgn(0, 12'h000, 12'h000);
    set_rgn(1, 12'h200, 12'hEFF);
    set_rgn(2, 12'h003, 12'h1FF);
    set_rgn(3, 12'h001, 12'h002);
    set_rgn(4, 12'h180, 12'h1FF);
    cfg_rd_perm = 5'b11011;
    cfg_wr_perm = 5'b11010;

    #12;
    chk("R8 reset status", {16'd0, sts_rdata}, 32'h2000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R4 strap high no override", {16'd0, sts_rdata}, 32'h2000);

    for (int k = 0; k < NV; k++) begin
      access(VEC[k][AW+1], VEC[k][AW:1], 32'hA500_0000 + k);
      chk("R1/R2/R3 grant", {31'd0, fl_req}, {31'd0, VEC[k][0]});
      chk("R6 deny flag", {31'd0, hst_deny}, {31'd0, ~VEC[k][0]});
      if (VEC[k][0]) begin
        chk("R6 fwd addr", {8'd0, fl_addr}, {8'd0, VEC[k][AW:1]});
        chk("R6 fwd data", fl_wdata, 32'hA500_0000 + k);
        chk("R6 fwd we", {31'd0, fl_we}, {31'd0, VEC[k][AW+1]});
      end
      err_exp = err_exp | ~VEC[k][0];
      idle_check_err("R7 sticky error", err_exp);
    end

    // R7 write 0 keeps, write 1 clears
    @(negedge clk); sts_wr = 1'b1; sts_wdata = 16'hFFFE;
    idle_check_err("R7 write zero keeps", 1'b1);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = 16'h0001;
    idle_check_err("R7 w1c clears", 1'b0);
    chk("R8 other bits zero", {16'd0, sts_rdata}, 32'h2000);

    // R7 set beats clear
    access(1'b0, 24'hF00000, 0);
    sts_wr = 1'b1; sts_wdata = 16'h0001;
    idle_check_err("R7 set wins over clear", 1'b1);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = 16'h0001;
    idle_check_err("R7 clear again", 1'b0);

    // R2 disabled region
    set_rgn(3, 12'h001, 12'h000);
    access(1'b0, 24'h001000, 0);
    chk("R2 disabled region denied", {31'd0, hst_deny}, 32'd1);
    idle_check_err("R7 after disabled deny", 1'b1);
    set_rgn(3, 12'h001, 12'h002);

    // R4/R5 override
    @(negedge clk); rst_n = 1'b0; strap_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R4 not sampled before edge", {16'd0, sts_rdata}, 32'h2000);
    @(negedge clk); #1;
    chk("R8 override status", {16'd0, sts_rdata}, 32'h0000);
    strap_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R4 strap change ignored", {16'd0, sts_rdata}, 32'h0000);
    access(1'b1, 24'h000010, 0);
    chk("R5 descriptor write", {31'd0, fl_req}, 32'd1);
    access(1'b0, 24'h003000, 0);
    chk("R5 me read", {31'd0, fl_req}, 32'd1);
    access(1'b1, 24'h180000, 0);
    chk("R5 overlap write", {31'd0, fl_req}, 32'd1);
    access(1'b0, 24'hF00000, 0);
    chk("R2 unmapped under override", {31'd0, hst_deny}, 32'd1);
    idle_check_err("R7 override deny", 1'b1);
    chk("R8 override with error", {16'd0, sts_rdata}, 32'h0001);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule